// File: doc/BRIEF.md
# 64-bit Cycle Counter with Torn-Read Detection

This block holds a 64-bit cycle counter that a 32-bit bus reads in two halves. Software reads the low half and then the high half. These are two separate accesses, so the pair can be torn in two ways. The low half can carry into the high half between the two accesses. An interrupt or exception can also split the two accesses. A small tracker watches the order of the accesses and keeps a status flag. The flag shows whether the pair just read is a consistent 64-bit snapshot.

The counter has three words at fixed addresses: a control word at 0x103, the low half at 0x104 and the high half at 0x105. Control bit 0 enables counting. Control bit 31 is the snapshot-valid flag. Software reads low, then high, then control, and repeats the three reads until bit 31 reads as 1. Read data is combinational and belongs to the cycle of the access. The exception input is a one-cycle pulse that reports a trap taken by the processor.

Top module: `cyc64_snap`

## Requirements
- R1: After reset the counter holds INIT_COUNT (zero by default), counting is disabled, and the control word reads 0.
- R2: A write to the control word (0x103) sets the enable from wdata bit 0. Control reads return the enable in bit 0 and the snapshot flag in bit 31, with every other bit 0.
- R3: While enabled, the counter advances by one every clock. While disabled, it holds. A read at 0x104 returns bits 31:0 and a read at 0x105 returns bits 63:32, both as they stand in the cycle of the read.
- R4: A low read followed later by a high read, with no exception and no carry in between, sets the snapshot flag (bit 31 = 1) from the cycle after the high read. The flag stays 1 across later control reads.
- R5: An exception pulse in the cycle of the low read, or in any cycle after it and before the high read, makes that pair invalid (bit 31 = 0). A pulse in the cycle of the high read itself does not.
- R6: A carry out of counter bit 31 makes the pair invalid. This applies to a carry at the clock edge that ends the low-read cycle, or at any later edge before the high-read cycle. A carry at the edge that ends the high-read cycle does not make the pair invalid.
- R7: A high read with no pending low read leaves bit 31 at 0. This covers a high read from the idle state, a second high read, and a high read after a control read that followed the low read.
- R8: A low read clears bit 31 from the next cycle.
- R9: Writes to 0x104 or 0x105 do not change the counter. Writes to the control word do not disturb the tracker. Reads of any other address return 0.
- R10: An exception pulse while no low read is pending leaves bit 31 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Bus access in this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current read access |
| exc_taken | input | 1 | One-cycle pulse: interrupt or exception taken |

## Verification
The bench drives clean low-high-control sequences, with and without idle cycles between the reads. These show that a good pair is accepted and that idle gaps do not matter. Exception pulses are placed in the low-read cycle, in a gap cycle, in the high-read cycle and outside any sequence, which marks the exact edges of the window the tracker watches. The counter starts just below a 32-bit wrap. The bench then puts the carry after the low read, at the low-read edge itself and at the high-read edge, which separates a torn pair from an edge case that is still valid. Sequences out of order, writes to the halves, writes to the control word in mid-sequence and reads of unmapped addresses show that only the intended order sets the flag.

// File: rtl/cyc64_snap.sv
module cyc64_snap #(
  parameter int          ADDR_W     = 12,
  parameter logic [63:0] INIT_COUNT = 64'd0,
  parameter int          A_CTL      = 'h103,
  parameter int          A_LO       = 'h104,
  parameter int          A_HI       = 'h105
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              exc_taken
);

  typedef enum logic [1:0] {T_IDLE, T_LOW, T_HIGH} trk_t;

  logic [63:0] cnt_q;
  logic        en_q;
  logic        ok_q;
  logic        bad_q;
  trk_t        st_q;

  logic hit_ctl, hit_lo, hit_hi;
  logic rd_ctl, rd_lo, rd_hi, wr_ctl;
  logic carry;
  logic taint;

  assign hit_ctl = addr == ADDR_W'(A_CTL);
  assign hit_lo  = addr == ADDR_W'(A_LO);
  assign hit_hi  = addr == ADDR_W'(A_HI);
  assign rd_ctl  = req && !we && hit_ctl;
  assign rd_lo   = req && !we && hit_lo;
  assign rd_hi   = req && !we && hit_hi;
  assign wr_ctl  = req &&  we && hit_ctl;
  assign carry   = en_q && (&cnt_q[31:0]);
  assign taint   = carry || exc_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= INIT_COUNT;
      en_q  <= 1'b0;
      ok_q  <= 1'b0;
      bad_q <= 1'b0;
      st_q  <= T_IDLE;
    end else begin
      if (en_q) cnt_q <= cnt_q + 64'd1;
      if (wr_ctl) en_q <= wdata[0];
      if (rd_lo) begin
        st_q  <= T_LOW;
        bad_q <= taint;
        ok_q  <= 1'b0;
      end else if (rd_hi) begin
        ok_q  <= (st_q == T_LOW) && !bad_q;
        st_q  <= ((st_q == T_LOW) && !bad_q) ? T_HIGH : T_IDLE;
        bad_q <= 1'b0;
      end else if (rd_ctl) begin
        st_q  <= T_IDLE;
        bad_q <= 1'b0;
      end else if (st_q == T_LOW && taint) begin
        bad_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (req && !we) begin
      if (hit_lo)       rdata = cnt_q[31:0];
      else if (hit_hi)  rdata = cnt_q[63:32];
      else if (hit_ctl) rdata = {ok_q, 30'd0, en_q};
    end
  end

endmodule

// File: rtl/cyc64_snap_chk.sv
module cyc64_snap_chk #(
  parameter int ADDR_W = 12,
  parameter int A_CTL  = 'h103,
  parameter int A_LO   = 'h104,
  parameter int A_HI   = 'h105
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [63:0]       cnt_q,
  input logic              en_q,
  input logic              ok_q
);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> cnt_q == $past(cnt_q) + 64'd1);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> cnt_q == $past(cnt_q));

  // R4
  ok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(req && !we && addr == ADDR_W'(A_HI)));

  // R8
  lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && addr == ADDR_W'(A_LO)) |=> !ok_q);

  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == ADDR_W'(A_CTL)) |=> en_q == $past(wdata[0]));

endmodule

bind cyc64_snap cyc64_snap_chk #(
  .ADDR_W(ADDR_W), .A_CTL(A_CTL), .A_LO(A_LO), .A_HI(A_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
  .wdata(wdata), .cnt_q(cnt_q), .en_q(en_q), .ok_q(ok_q)
);

// File: tb/cyc64_snap_bench.sv
`timescale 1ns/1ps
module cyc64_snap_bench;
  localparam int          AW   = 12;
  localparam logic [63:0] INIT = 64'h0000_0007_FFFF_FF00;
  localparam logic [AW-1:0] CTL = 12'h103, LO = 12'h104, HI = 12'h105;

  logic clk = 0, rst_n = 0, req = 0, we = 0, exc = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;

  cyc64_snap #(.ADDR_W(AW), .INIT_COUNT(INIT)) u_cyc64_snap (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .exc_taken(exc));

  always #2 clk = ~clk;

  logic [63:0] mcnt;
  logic        men;
  always @(posedge clk) begin
    if (!rst_n) begin mcnt <= INIT; men <= 0; end
    else begin
      if (men) mcnt <= mcnt + 64'd1;
      if (req && we && addr == CTL) men <= wdata[0];
    end
  end

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(negedge clk) begin
    #1;
    if (req && !we) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: read with no expectation got %h exp none", rdata);
      end else begin
        logic [31:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        n_cmp++;
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: got %h exp %h", t, rdata, e);
        end
      end
    end
  end

  task automatic cyc(input logic r, input logic w, input logic [AW-1:0] a,
                     input logic [31:0] d, input logic x);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; exc = x;
  endtask

  task automatic idle(input logic x = 0); cyc(0, 0, '0, '0, x); endtask
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d); cyc(1, 1, a, d, 0); endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t,
                    input logic x = 0);
    cyc(1, 0, a, '0, x);
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic rd_lo(input string t, input logic x = 0);
    cyc(1, 0, LO, '0, x);
    exp_q.push_back(mcnt[31:0]); tag_q.push_back(t);
  endtask

  task automatic rd_hi(input string t, input logic x = 0);
    cyc(1, 0, HI, '0, x);
    exp_q.push_back(mcnt[63:32]); tag_q.push_back(t);
  endtask

  task automatic rd_ctl(input logic ok, input string t);
    cyc(1, 0, CTL, '0, 0);
    exp_q.push_back({ok, 30'd0, men}); tag_q.push_back(t);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req = 0; we = 0; exc = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_low(input logic [31:0] v);
    while (mcnt[31:0] != v) idle();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    rd(CTL, 32'h0, "R1 ctrl after reset");
    rd(LO, INIT[31:0], "R1 low after reset");
    rd(HI, INIT[63:32], "R1 high after reset");
    idle(); idle();
    rd(LO, INIT[31:0], "R3 disabled holds");

    wr(CTL, 32'h1);
    idle();
    rd_ctl(0, "R2 enable readback");
    rd_lo("R3 low counting");
    rd_lo("R3 low next cycle");
    rd_hi("R3 high counting");

    rd_lo("R4 low"); rd_hi("R4 high"); rd_ctl(1, "R4 clean pair");
    rd_ctl(1, "R4 flag holds");
    rd_lo("R4 low gap"); idle(); idle(); rd_hi("R4 high gap"); rd_ctl(1, "R4 pair with gap");

    idle(1); idle(); rd_ctl(1, "R10 exception outside sequence");

    rd_lo("R8 low"); rd_ctl(0, "R8 low clears flag");
    rd_hi("R7 high after ctrl"); rd_ctl(0, "R7 high after ctrl read");
    rd_hi("R7 high idle"); rd_ctl(0, "R7 high from idle");
    rd_lo("R7 low"); rd_hi("R7 high1"); rd_hi("R7 high2"); rd_ctl(0, "R7 second high");

    rd_lo("R5 low"); idle(1); rd_hi("R5 high"); rd_ctl(0, "R5 exception in gap");
    rd_lo("R5 low exc", 1); rd_hi("R5 high b"); rd_ctl(0, "R5 exception in low cycle");
    rd_lo("R5 low c"); rd_hi("R5 high exc", 1); rd_ctl(1, "R5 exception in high cycle");

    rd_lo("R9 low a"); rd_hi("R9 high a"); wr(CTL, 32'hFFFF_FFFF); rd_ctl(1, "R9 ctrl write keeps tracker");
    rd_ctl(1, "R2 other ctrl bits read zero");
    wr(LO, 32'h1234_5678); wr(HI, 32'hDEAD_BEEF);
    rd_lo("R9 low write ignored"); rd_hi("R9 high write ignored");
    rd(12'h0FF, 32'h0, "R9 unmapped read");

    wait_low(32'hFFFF_FFFD);
    rd_lo("R6 low before wrap"); idle(); rd_hi("R6 high after wrap"); rd_ctl(0, "R6 carry after low");
    rd_lo("R6 low after wrap"); rd_hi("R6 high settled"); rd_ctl(1, "R6 clean after wrap");

    do_reset(); wr(CTL, 32'h1);
    wait_low(32'hFFFF_FFFE);
    rd_lo("R6 low at all ones"); rd_hi("R6 high next"); rd_ctl(0, "R6 carry at low edge");

    do_reset(); wr(CTL, 32'h1);
    wait_low(32'hFFFF_FFFD);
    rd_lo("R6 low b"); rd_hi("R6 high at all ones"); rd_ctl(1, "R6 carry at high edge ok");

    wr(CTL, 32'h0); idle();
    rd_ctl(1, "R2 disable readback");

    idle(); idle();
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: got %0d pending exp 0", exp_q.size());
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule